// File: doc/BRIEF.md
# LED Matrix Column-Scan Driver

This block sits between a host that only writes registers and a multiplexed LED display of five rows by sixteen columns. The host writes an upper byte, which holds a column number and a display-style flag, and then a lower byte, which holds a five-bit level. Each lower-byte write starts one column update. The block drives the five row lines directly. It also produces the three serial control lines for an external chain of latching serial-in/parallel-out shift registers that choose the active column: a serial data bit, a shift clock and a storage latch clock.

For each update, the block presents a serial data bit that is high only for column zero. It then gives one shift pulse followed by one latch pulse. The result is a single token that enters the chain once per frame and moves one position on every update, so exactly one column is lit at a time. The row lines change on the same edge that raises the latch pulse, so the previous column never shows the new row data. Two row styles are available: the five level bits passed straight through, or a bar graph that fills from the bottom row up.

The host interface has no back-pressure. The host is expected to pace its writes, for example one update per millisecond, which gives a 16 ms frame. A write that arrives while a pulse sequence is still running is held in a one-entry slot and started as soon as the running sequence completes.

Top module: `led_scan_ctrl`

## Requirements
- R1: When `hi_we` is high, the block stores `wr_data[3:0]` as the column number and `wr_data[4]` as the style flag. `wr_data[7:5]` is ignored on every write. An upper-byte write alone produces no shift pulse and changes neither `ser_data` nor the row lines.
- R2: A lower-byte write (`lo_we` high, level in `wr_data[4:0]`) that is sampled at rising edge k while the block is idle raises `shift_clk` at edge k+2 for exactly one clock cycle.
- R3: `latch_clk` is high for exactly the one clock cycle that immediately follows each `shift_clk` pulse. The two pulses never overlap.
- R4: From edge k onwards, `ser_data` is 1 if the column number of the started update is 0 and 0 otherwise. It is held at that value through the shift pulse.
- R5: With the style flag at 0, row line i equals level bit i.
- R6: With the style flag at 1, row line i (where row 0 is the bottom row) is 1 exactly when the level is greater than i. A level of 0 lights no row, and any level of 5 or more lights all five rows.
- R7: The row lines take the new update's pattern on the edge that raises `latch_clk`, and they hold their value on every other edge.
- R8: A lower-byte write that arrives while a sequence is running waits in a single slot and starts on the edge that ends the running latch pulse. A later write into an occupied slot replaces the waiting entry. The waiting entry pairs its level with the column and flag that were stored when it was written.
- R9: A synchronous active-high `rst` clears the stored registers and the waiting slot, and drives `ser_data`, `shift_clk`, `latch_clk` and all row lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_we | input | 1 | Upper-byte write strobe (column number and style flag) |
| lo_we | input | 1 | Lower-byte write strobe (level); starts an update |
| wr_data | input | 8 | Write data shared by both strobes |
| row_o | output | 5 | Row drive lines, bit 0 is the bottom row |
| ser_data | output | 1 | Serial data bit into the column chain |
| shift_clk | output | 1 | One-cycle shift pulse for the column chain |
| latch_clk | output | 1 | One-cycle storage latch pulse for the column chain |

## Verification
The assertions check the relationships between pulses on every cycle: each shift pulse is one cycle wide and is followed at once by a latch pulse, the serial bit holds steady during the shift pulse, the row lines change only as a latch pulse rises, and reset leaves every output low. Only the bench scenarios can show the values: which row pattern each style and level produces across all 32 levels, that the serial bit is high only for column zero, that the pulses arrive at the exact latency after a write, and that writes arriving mid-sequence are queued and replaced correctly.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int unsigned ROWS     = 5;
  localparam int unsigned LVL_W    = 5;
  localparam int unsigned COL_W    = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MODE_BIT = COL_W;

  typedef struct packed {
    logic             bar_mode;
    logic [COL_W-1:0] col;
    logic [LVL_W-1:0] level;
  } scan_word_t;
endpackage

// File: rtl/led_host_regs.sv
module led_host_regs
  import led_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output scan_word_t        out_word
);
  logic             hi_mode;
  logic [COL_W-1:0] hi_col;
  logic             pend_v;
  scan_word_t       pend_w;
  scan_word_t       new_w;
  logic             fire;
  logic             keep_new;
  logic             unused_top_bits;

  assign unused_top_bits = ^wr_data[BYTE_W-1:MODE_BIT+1];

  always_comb begin
    new_w.bar_mode = hi_mode;
    new_w.col      = hi_col;
    new_w.level    = wr_data[LVL_W-1:0];
  end

  // the waiting slot has priority over a fresh write
  assign out_valid = pend_v | lo_we;
  assign out_word  = pend_v ? pend_w : new_w;
  assign fire      = out_valid & out_ready;
  // a fresh write is kept unless it went straight out
  assign keep_new  = lo_we & ~(fire & ~pend_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_mode <= 1'b0;
      hi_col  <= '0;
      pend_v  <= 1'b0;
      pend_w  <= '0;
    end else begin
      if (hi_we) begin
        hi_col  <= wr_data[COL_W-1:0];
        hi_mode <= wr_data[MODE_BIT];
      end
      pend_v <= (pend_v & ~fire) | keep_new;
      if (keep_new) pend_w <= new_w;
    end
  end
endmodule

// File: rtl/led_pulse_seq.sv
module led_pulse_seq
  import led_scan_pkg::*;
#(
  parameter int unsigned DLY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  scan_word_t in_word,
  output scan_word_t cur_word,
  output logic       ser_data,
  output logic       shift_clk,
  output logic       latch_clk
);
  logic [DLY-1:0] dly;
  logic           start;

  assign in_ready = ~(|dly) & ~shift_clk;
  assign start    = in_valid & in_ready;

  for (genvar i = 0; i < DLY; i++) begin : g_dly
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) dly[0] <= 1'b0;
        else     dly[0] <= start;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) dly[i] <= 1'b0;
        else     dly[i] <= dly[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_clk <= 1'b0;
      latch_clk <= 1'b0;
      ser_data  <= 1'b0;
      cur_word  <= '0;
    end else begin
      shift_clk <= dly[DLY-1];
      latch_clk <= shift_clk;
      if (start) begin
        cur_word <= in_word;
        ser_data <= (in_word.col == '0);
      end
    end
  end
endmodule

// File: rtl/led_row_pattern.sv
module led_row_pattern
  import led_scan_pkg::*;
(
  input  scan_word_t      word,
  output logic [ROWS-1:0] pattern
);
  logic [ROWS-1:0] bar;

  for (genvar i = 0; i < ROWS; i++) begin : g_bar
    assign bar[i] = (word.level > LVL_W'(i));
  end

  assign pattern = word.bar_mode ? bar : word.level[ROWS-1:0];
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [ROWS-1:0]   row_o,
  output logic              ser_data,
  output logic              shift_clk,
  output logic              latch_clk
);
  logic            req_valid;
  logic            req_ready;
  scan_word_t      req_word;
  scan_word_t      cur_word;
  logic [ROWS-1:0] pattern;

  led_host_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .hi_we     (hi_we),
    .lo_we     (lo_we),
    .wr_data   (wr_data),
    .out_valid (req_valid),
    .out_ready (req_ready),
    .out_word  (req_word)
  );

  led_pulse_seq #(.DLY(2)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_word   (req_word),
    .cur_word  (cur_word),
    .ser_data  (ser_data),
    .shift_clk (shift_clk),
    .latch_clk (latch_clk)
  );

  led_row_pattern u_pat (
    .word    (cur_word),
    .pattern (pattern)
  );

  // rows load on the edge that raises the latch pulse
  always_ff @(posedge clk) begin
    if (rst)            row_o <= '0;
    else if (shift_clk) row_o <= pattern;
  end
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk
  import led_scan_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_o,
  input logic            ser_data,
  input logic            shift_clk,
  input logic            latch_clk
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (row_o == '0 && !ser_data && !shift_clk && !latch_clk)); // R9

  AST_SHIFT_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    shift_clk |=> !shift_clk); // R2

  AST_SHIFT_THEN_LATCH: assert property (@(posedge clk) disable iff (rst)
    shift_clk |=> latch_clk); // R3

  AST_LATCH_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    latch_clk |-> $past(shift_clk)); // R3

  AST_NO_PULSE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(shift_clk && latch_clk)); // R3

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    shift_clk |-> $stable(ser_data)); // R4

  AST_ROWS_AT_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_o) |-> $rose(latch_clk)); // R7
endmodule

bind led_scan_ctrl led_scan_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .row_o     (row_o),
  .ser_data  (ser_data),
  .shift_clk (shift_clk),
  .latch_clk (latch_clk)
);

// File: tb/led_scan_ctrl_tb.sv
module led_scan_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       hi_we;
  logic       lo_we;
  logic [7:0] wr_data;
  logic [4:0] row_o;
  logic       ser_data;
  logic       shift_clk;
  logic       latch_clk;
  int n_chk = 0;
  int n_err = 0;
  int shifts = 0;

  always #4 clk = ~clk;

  led_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data),
    .row_o(row_o), .ser_data(ser_data), .shift_clk(shift_clk), .latch_clk(latch_clk)
  );

  always @(posedge clk) if (shift_clk) shifts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rows(input int mode, input int lvl);
    int n;
    if (mode == 0) return lvl & 31;
    n = (lvl > 5) ? 5 : lvl;
    return (1 << n) - 1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_hi(input int col, input int mode);
    hi_we = 1'b1;
    wr_data = {3'b101, mode[0], col[3:0]};
    tick();
    hi_we = 1'b0;
  endtask

  task automatic put_lo(input int lvl);
    lo_we = 1'b1;
    wr_data = {3'b110, lvl[4:0]};
    tick();
    lo_we = 1'b0;
  endtask

  task automatic run_update(input int col, input int mode, input int lvl);
    int prev;
    int er;
    string rq;
    rq = (mode != 0) ? "R6" : "R5";
    er = exp_rows(mode, lvl);
    put_hi(col, mode);
    prev = row_o;
    put_lo(lvl);                         // edge k passed
    chk(ser_data == (col == 0), "R1 R4 ser_data", ser_data, col == 0);
    chk(!shift_clk, "R2 early shift", shift_clk, 0);
    tick();                              // k+1
    chk(!shift_clk, "R2 early shift", shift_clk, 0);
    tick();                              // k+2
    chk(shift_clk && !latch_clk, "R2 shift pulse", {shift_clk, latch_clk}, 2);
    chk(row_o == prev, "R7 rows held", row_o, prev);
    tick();                              // k+3
    chk(latch_clk && !shift_clk, "R3 latch pulse", {shift_clk, latch_clk}, 1);
    chk(row_o == er, rq, row_o, er);
    tick();                              // k+4
    chk(!latch_clk, "R3 latch width", latch_clk, 0);
  endtask

  initial begin
    rst = 1'b1; hi_we = 1'b0; lo_we = 1'b0; wr_data = '0;
    repeat (3) tick();
    chk(row_o == 0 && !ser_data && !shift_clk && !latch_clk, "R9 reset state",
        {row_o, ser_data, shift_clk, latch_clk}, 0);
    rst = 1'b0;
    tick();

    // sweep both styles over all levels, columns cycling
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 32; v++)
        run_update(v % 16, m, v);

    // R1: upper-byte write alone starts nothing
    begin
      int s0, r0, d0;
      s0 = shifts; r0 = row_o; d0 = ser_data;
      put_hi(0, 0);
      repeat (6) tick();
      chk(shifts == s0, "R1 no shift from upper write", shifts, s0);
      chk(row_o == r0 && ser_data == d0, "R1 outputs unchanged",
          {row_o, ser_data}, {r0[4:0], d0[0]});
    end

    // R8: queued writes, latest wins
    begin
      int s0;
      put_hi(5, 0);
      lo_we = 1'b1; wr_data = 8'd19;      // A at edge k
      tick();
      lo_we = 1'b0; hi_we = 1'b1; wr_data = {3'b000, 1'b1, 4'd0};
      tick();                              // k+1
      hi_we = 1'b0; lo_we = 1'b1; wr_data = 8'd1;   // B at k+2
      tick();
      chk(shift_clk, "R8 first shift", shift_clk, 1);
      wr_data = 8'd3;                      // C at k+3 replaces B
      tick();
      lo_we = 1'b0;
      chk(latch_clk && row_o == 19, "R8 first rows", row_o, 19);
      s0 = shifts;
      tick();                              // k+4: queued start
      chk(ser_data, "R8 queued ser_data", ser_data, 1);
      chk(row_o == 19, "R8 rows hold", row_o, 19);
      tick();
      chk(!shift_clk, "R8 queued early", shift_clk, 0);
      tick();                              // k+6
      chk(shift_clk, "R8 queued shift", shift_clk, 1);
      tick();                              // k+7
      chk(latch_clk && row_o == exp_rows(1, 3), "R8 latest wins", row_o, exp_rows(1, 3));
      repeat (6) tick();
      chk(shifts == s0 + 1, "R8 single queued start", shifts - s0, 1);
    end

    // R9: mid-run reset
    put_hi(0, 1);
    put_lo(31);
    rst = 1'b1;
    repeat (2) tick();
    chk(row_o == 0 && !ser_data && !shift_clk && !latch_clk, "R9 reset clears",
        {row_o, ser_data, shift_clk, latch_clk}, 0);
    rst = 1'b0;
    repeat (6) tick();
    chk(shifts == shifts && !shift_clk && row_o == 0, "R9 slot cleared", row_o, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule